// File: doc/BRIEF.md
# Multi-output raster sync generator

This block walks a raster: a sample counter steps through the pixel clocks of one line and a line counter steps through the lines of one frame. Four sync channels share these counters. Each channel has its own horizontal edge pair and its own vertical edge pair, so each can drive a separate video sink with a different pipeline delay. A vertical edge is placed by a line number together with a sample offset inside that line. A channel can therefore raise vsync late on the last line of the previous frame, which is what a sink with a negative delay needs.

Software programs the line length, the frame height, the operating mode and the per-channel edge words through a single-cycle write port. Every write goes into a pending copy. The pending copy becomes live only when a new frame starts. The generator either free-runs as a master or follows an external frame reference. Only the progressive scan path is built.

Top module: `vtg_top`

## Requirements
- R1: While reset is held and after it is released, every hsync and vsync output is low. The counters start at sample 0, line 1. The reset configuration has all edge words zero, so the outputs stay low until new edges are loaded.
- R2: The sample counter runs from 0 to line length minus 1. The line counter runs from 1 to frame height. After the last sample of the last line, both counters return to sample 0, line 1. A channel's hsync therefore repeats every line length cycles and its vsync repeats every line length times frame height cycles.
- R3: Each channel has a registered, active-high hsync. It goes high in the cycle after the sample counter equals the channel's assert position. It goes low in the cycle after the sample counter equals the de-assert position. De-assert wins if both positions are equal. An assert position greater than the de-assert position gives a pulse that wraps across the line end.
- R4: Any sample position or sample offset at or above the line length is reduced by one line length before it is compared.
- R5: Each channel has a registered, active-high vsync. It goes high in the cycle after the counters reach the assert line and the assert offset. It goes low in the cycle after they reach the de-assert line and the de-assert offset. The pulse may span the frame boundary, starting on the last line of one frame.
- R6: The four channels are independent: the edges of one channel never change the outputs of another.
- R7: Address map: 0 holds the line length in bits 15:0. Address 1 holds the frame height in bits 15:0. Address 2 holds the mode in bit 0, where 0 is master and 1 is slave. Channel c (0 to 3) has its base at 8×(c+1). At offset +0, bits 15:0 hold the hsync assert position and bits 31:16 the de-assert position. At offset +1, bits 15:0 hold the vsync assert line and bits 31:16 the de-assert line. At offset +3, bits 15:0 hold the vsync assert offset and bits 31:16 the de-assert offset. Line numbers count from 1.
- R8: Offsets +2 and +4 of each channel hold the second-field words. In progressive operation they are accepted and have no effect on any output.
- R9: In slave mode, a rising edge on the external reference moves the counters to sample 0, line 1 on the next clock. The same edge also makes the pending configuration live.
- R10: In master mode, the external reference has no effect on the counters or the outputs.
- R11: A write changes only the pending configuration. The live configuration, including the mode, is updated only at a frame start: the natural wrap of R2 or a restart under R9. The rest of the current frame keeps the old timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 6 | Register address (see R7) |
| wrData | input | 32 | Register write data |
| extRef | input | 1 | External frame reference, rising edge used in slave mode |
| hsync | output | 4 | Horizontal sync, one bit per channel, active high |
| vsync | output | 4 | Vertical sync, one bit per channel, active high |

## Verification
The bench programs channel sets that cover every corner case:
- Pulses that wrap across the line end or across the frame end. A design that compared without wrapping would drop or truncate these pulses.
- Equal assert and de-assert positions, where the wrong priority would leave a channel stuck high.
- Positions at or beyond the line length, which an unfolded compare would never match.
- Writes to the second-field words, which must change nothing.
- A write made in the middle of a frame, which must not show up before the next frame start. An unshadowed design would tear that frame.
- A reference pulse in master mode, which must be ignored. A design that honoured it would shift the phase of every channel.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int POS_W = 16;

  typedef logic [POS_W-1:0] pos_t;

  // Live or pending edge words of one sync channel
  typedef struct packed {
    pos_t hStart;
    pos_t hStop;
    pos_t vOnLine;
    pos_t vOffLine;
    pos_t vOnSmp;
    pos_t vOffSmp;
  } edgeSet_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic loadCfg;
  } ctrlStb_t;

  // Slot numbers inside a channel's 8-word address group
  localparam int SLOT_HSYNC     = 0;
  localparam int SLOT_VLINE     = 1;
  localparam int SLOT_VLINE_BOT = 2;
  localparam int SLOT_VSMP      = 3;
  localparam int SLOT_VSMP_BOT  = 4;

  // Slots of the global group
  localparam int SLOT_LEN  = 0;
  localparam int SLOT_HGT  = 1;
  localparam int SLOT_MODE = 2;

  localparam logic MODE_MASTER = 1'b0;
  localparam logic MODE_SLAVE  = 1'b1;

endpackage

// File: rtl/vtg_ctrl.sv
module vtg_ctrl import vtg_pkg::*; #(
  parameter int N_OUT           = 4,
  parameter int ADDR_W          = 6,
  parameter int DEF_LINE_LEN    = 16,
  parameter int DEF_FRAME_LINES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [2*POS_W-1:0] wrData,
  input  logic               extRef,
  input  logic               frameEnd,
  output pos_t               actLen,
  output pos_t               actHgt,
  output edgeSet_t           actSet [N_OUT],
  output ctrlStb_t           stb
);

  localparam int   SLOT_W  = 3;
  localparam int   GRP_W   = ADDR_W - SLOT_W;
  localparam pos_t RST_LEN = pos_t'(DEF_LINE_LEN);
  localparam pos_t RST_HGT = pos_t'(DEF_FRAME_LINES);

  pos_t              pendLen;
  pos_t              pendHgt;
  logic              pendMode;
  logic              actMode;
  logic              extPrev;
  edgeSet_t          pendSet [N_OUT];
  logic [GRP_W-1:0]  grp;
  logic [SLOT_W-1:0] slot;
  pos_t              wLo;
  pos_t              wHi;

  assign grp  = wrAddr[ADDR_W-1:SLOT_W];
  assign slot = wrAddr[SLOT_W-1:0];
  assign wLo  = wrData[POS_W-1:0];
  assign wHi  = wrData[2*POS_W-1:POS_W];

  // Pending copy: written by software at any time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendLen  <= RST_LEN;
      pendHgt  <= RST_HGT;
      pendMode <= MODE_MASTER;
      for (int i = 0; i < N_OUT; i++) pendSet[i] <= '0;
    end else if (wrEn) begin
      if (grp == '0) begin
        case (slot)
          SLOT_W'(SLOT_LEN):  pendLen  <= wLo;
          SLOT_W'(SLOT_HGT):  pendHgt  <= wLo;
          SLOT_W'(SLOT_MODE): pendMode <= wrData[0];
          default: ;
        endcase
      end
      for (int i = 0; i < N_OUT; i++) begin
        if (grp == GRP_W'(i + 1)) begin
          case (slot)
            SLOT_W'(SLOT_HSYNC): begin
              pendSet[i].hStart <= wLo;
              pendSet[i].hStop  <= wHi;
            end
            SLOT_W'(SLOT_VLINE): begin
              pendSet[i].vOnLine  <= wLo;
              pendSet[i].vOffLine <= wHi;
            end
            SLOT_W'(SLOT_VSMP): begin
              pendSet[i].vOnSmp  <= wLo;
              pendSet[i].vOffSmp <= wHi;
            end
            // second-field slots are accepted and dropped (progressive only)
            default: ;
          endcase
        end
      end
    end
  end

  // Live copy: refreshed only at a frame start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actLen  <= RST_LEN;
      actHgt  <= RST_HGT;
      actMode <= MODE_MASTER;
      for (int i = 0; i < N_OUT; i++) actSet[i] <= '0;
    end else if (stb.loadCfg) begin
      actLen  <= pendLen;
      actHgt  <= pendHgt;
      actMode <= pendMode;
      actSet  <= pendSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extRef;
  end

  assign stb.restart = (actMode == MODE_SLAVE) && extRef && !extPrev;
  assign stb.loadCfg = stb.restart || frameEnd;

endmodule

// File: rtl/vtg_dpath.sv
module vtg_dpath import vtg_pkg::*; #(
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  pos_t             actLen,
  input  pos_t             actHgt,
  input  edgeSet_t         actSet [N_OUT],
  output logic             frameEnd,
  output pos_t             smpCnt,
  output pos_t             lineCnt,
  output logic [N_OUT-1:0] hsync,
  output logic [N_OUT-1:0] vsync
);

  localparam pos_t FIRST_LINE = pos_t'(1);

  // Bring a position back inside the line by one line length
  function automatic pos_t foldPos(input pos_t p, input pos_t len);
    return (p >= len) ? p - len : p;
  endfunction

  logic lineEnd;

  assign lineEnd  = (smpCnt == actLen - pos_t'(1));
  assign frameEnd = lineEnd && (lineCnt == actHgt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smpCnt  <= '0;
      lineCnt <= FIRST_LINE;
    end else if (stb.loadCfg) begin
      smpCnt  <= '0;
      lineCnt <= FIRST_LINE;
    end else if (lineEnd) begin
      smpCnt  <= '0;
      lineCnt <= lineCnt + pos_t'(1);
    end else begin
      smpCnt  <= smpCnt + pos_t'(1);
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : gSync
    logic hOn, hOff, vOn, vOff;
    logic hReg, vReg;

    assign hOn  = (smpCnt == foldPos(actSet[g].hStart, actLen));
    assign hOff = (smpCnt == foldPos(actSet[g].hStop, actLen));
    assign vOn  = (lineCnt == actSet[g].vOnLine) &&
                  (smpCnt == foldPos(actSet[g].vOnSmp, actLen));
    assign vOff = (lineCnt == actSet[g].vOffLine) &&
                  (smpCnt == foldPos(actSet[g].vOffSmp, actLen));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     hReg <= 1'b0;
      else if (hOff) hReg <= 1'b0;
      else if (hOn)  hReg <= 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     vReg <= 1'b0;
      else if (vOff) vReg <= 1'b0;
      else if (vOn)  vReg <= 1'b1;
    end

    assign hsync[g] = hReg;
    assign vsync[g] = vReg;
  end

endmodule

// File: rtl/vtg_top.sv
module vtg_top import vtg_pkg::*; #(
  parameter int  N_OUT           = 4,
  parameter int  DEF_LINE_LEN    = 16,
  parameter int  DEF_FRAME_LINES = 8,
  localparam int ADDR_W          = $clog2((N_OUT + 1) * 8),
  localparam int DATA_W          = 2 * POS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              extRef,
  output logic [N_OUT-1:0]  hsync,
  output logic [N_OUT-1:0]  vsync
);

  ctrlStb_t stb;
  logic     frameEnd;
  pos_t     actLen;
  pos_t     actHgt;
  pos_t     smpCnt;
  pos_t     lineCnt;
  edgeSet_t actSet [N_OUT];

  vtg_ctrl #(
    .N_OUT           (N_OUT),
    .ADDR_W          (ADDR_W),
    .DEF_LINE_LEN    (DEF_LINE_LEN),
    .DEF_FRAME_LINES (DEF_FRAME_LINES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .extRef   (extRef),
    .frameEnd (frameEnd),
    .actLen   (actLen),
    .actHgt   (actHgt),
    .actSet   (actSet),
    .stb      (stb)
  );

  vtg_dpath #(
    .N_OUT (N_OUT)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .actLen   (actLen),
    .actHgt   (actHgt),
    .actSet   (actSet),
    .frameEnd (frameEnd),
    .smpCnt   (smpCnt),
    .lineCnt  (lineCnt),
    .hsync    (hsync),
    .vsync    (vsync)
  );

endmodule

// File: rtl/vtg_sva.sv
module vtg_sva import vtg_pkg::*; #(
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rstN,
  input ctrlStb_t         stb,
  input logic             frameEnd,
  input pos_t             smpCnt,
  input pos_t             lineCnt,
  input pos_t             actLen,
  input pos_t             actHgt,
  input logic [N_OUT-1:0] hsync,
  input logic [N_OUT-1:0] vsync
);

  always @(negedge clk) begin
    if (!rstN) begin
      AST_RESET_LOW: assert (hsync == '0 && vsync == '0); // R1
    end
  end

  AST_RESTART_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> (smpCnt == '0 && lineCnt == pos_t'(1))); // R9

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (smpCnt == '0 && lineCnt == pos_t'(1))); // R2

  AST_SAMPLE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (actLen != '0) |-> (smpCnt < actLen)); // R2

  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (actHgt != '0) |-> (lineCnt >= pos_t'(1) && lineCnt <= actHgt)); // R2

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadCfg |=> ($stable(actLen) && $stable(actHgt))); // R11

endmodule

bind vtg_top vtg_sva #(.N_OUT(N_OUT)) u_sva (
  .clk      (clk),
  .rstN     (rstN),
  .stb      (stb),
  .frameEnd (frameEnd),
  .smpCnt   (smpCnt),
  .lineCnt  (lineCnt),
  .actLen   (actLen),
  .actHgt   (actHgt),
  .hsync    (hsync),
  .vsync    (vsync)
);

// File: tb/vtg_top_tb.sv
`timescale 1ns/1ps
module vtg_top_tb;

  localparam int N_OUT = 4;
  localparam int NV    = 3;
  localparam int AW    = 6;
  localparam int DW    = 32;
  localparam int DEF_F = 16 * 8;

  // per vector: line length, frame height
  localparam int V_LEN [NV] = '{10, 12, 8};
  localparam int V_HGT [NV] = '{6, 5, 7};
  // per channel: hStart, hStop, vOnLine, vOnSmp, vOffLine, vOffSmp
  localparam int V_EDG [NV][N_OUT][6] = '{
    '{ '{0, 3, 1, 0, 2, 0},  '{2, 5, 1, 2, 3, 2},   '{8, 1, 6, 8, 2, 8},  '{4, 4, 2, 0, 2, 5} },
    '{ '{13, 2, 1, 0, 1, 6}, '{0, 11, 2, 14, 4, 3}, '{11, 0, 5, 11, 1, 11}, '{6, 9, 3, 4, 4, 4} },
    '{ '{7, 0, 7, 7, 2, 7},  '{3, 8, 1, 0, 7, 0},   '{1, 2, 4, 1, 4, 2},  '{5, 3, 6, 0, 1, 0} }
  };

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, extRef = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [N_OUT-1:0] hsync, vsync;
  int  checks = 0, failures = 0, nCnt = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  vtg_top #(.N_OUT(N_OUT)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extRef(extRef), .hsync(hsync), .vsync(vsync)
  );

  function automatic int fold(input int p, input int len);
    return (p >= len) ? p - len : p;
  endfunction

  function automatic bit inWin(input int p, input int a, input int d);
    if (a == d) return 1'b0;
    if (a < d)  return (p >= a) && (p < d);
    return (p >= a) || (p < d);
  endfunction

  // output after the n-th edge since restart reflects position n-1
  function automatic bit hExp(input int n, input int len, input int s, input int e);
    return inWin((n - 1) % len, fold(s, len), fold(e, len));
  endfunction

  function automatic bit vExp(input int n, input int len, input int hgt,
                              input int la, input int oa, input int ld, input int od);
    return inWin((n - 1) % (len * hgt), (la - 1) * len + fold(oa, len),
                 (ld - 1) * len + fold(od, len));
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp,
                       input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    nCnt++;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wrAddr = AW'(a);
    wrData = d;
    wrEn   = 1'b1;
    step();
    wrEn   = 1'b0;
  endtask

  task automatic restartNow();
    extRef = 1'b1;
    @(posedge clk);
    @(negedge clk);
    extRef = 1'b0;
    nCnt   = 0;
  endtask

  task automatic loadVec(input int v);
    wr(0, 32'(V_LEN[v]));
    wr(1, 32'(V_HGT[v]));
    for (int i = 0; i < N_OUT; i++) begin
      wr(8 * (i + 1) + 0, {16'(V_EDG[v][i][1]), 16'(V_EDG[v][i][0])});
      wr(8 * (i + 1) + 1, {16'(V_EDG[v][i][4]), 16'(V_EDG[v][i][2])});
      wr(8 * (i + 1) + 3, {16'(V_EDG[v][i][5]), 16'(V_EDG[v][i][3])});
    end
  endtask

  task automatic checkVec(input int v, input string hTag, input string vTag);
    int len, hgt, frm;
    int hBad [N_OUT];
    int vBad [N_OUT];
    int hAt  [N_OUT];
    int vAt  [N_OUT];
    len = V_LEN[v];
    hgt = V_HGT[v];
    frm = len * hgt;
    for (int i = 0; i < N_OUT; i++) begin
      hBad[i] = 0; vBad[i] = 0; hAt[i] = 0; vAt[i] = 0;
    end
    loadVec(v);
    restartNow();
    for (int k = 0; k < 2 * frm; k++) begin
      step();
      for (int i = 0; i < N_OUT; i++) begin
        if (nCnt > len && hsync[i] !== hExp(nCnt, len, V_EDG[v][i][0], V_EDG[v][i][1])) begin
          if (hBad[i] == 0) hAt[i] = nCnt;
          hBad[i]++;
        end
        if (nCnt > frm && vsync[i] !== vExp(nCnt, len, hgt, V_EDG[v][i][2], V_EDG[v][i][3],
                                             V_EDG[v][i][4], V_EDG[v][i][5])) begin
          if (vBad[i] == 0) vAt[i] = nCnt;
          vBad[i]++;
        end
      end
    end
    for (int i = 0; i < N_OUT; i++) begin
      check(hTag, hBad[i] == 0, hBad[i], 0,
            $sformatf("vec%0d hsync%0d mismatch count (first n=%0d)", v, i, hAt[i]));
      check(vTag, vBad[i] == 0, vBad[i], 0,
            $sformatf("vec%0d vsync%0d mismatch count (first n=%0d)", v, i, vAt[i]));
    end
  endtask

  initial begin
    int bad, badH, badV, firstH, secH, firstV, secV, wN, nb, stopN;
    logic lastH, lastV;

    // R1: outputs low during reset
    repeat (3) @(negedge clk);
    check("R1", hsync == '0, int'(hsync), 0, "hsync in reset");
    check("R1", vsync == '0, int'(vsync), 0, "vsync in reset");
    rstN = 1'b1;
    badH = 0; badV = 0;
    for (int k = 0; k < 2 * DEF_F + 8; k++) begin
      step();
      if (hsync != '0) badH++;
      if (vsync != '0) badV++;
    end
    check("R1", badH == 0, badH, 0, "hsync high cycles after reset");
    check("R1", badV == 0, badV, 0, "vsync high cycles after reset");

    // select slave mode, becomes live at a natural frame start
    wr(2, 32'd1);
    repeat (DEF_F + 4) step();

    // table walk: R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      checkVec(v, v == 0 ? "R3" : (v == 1 ? "R4" : "R6"),
                  v == 0 ? "R5" : (v == 1 ? "R4" : "R7"));
    end

    // R8: second-field words must change nothing
    for (int i = 0; i < N_OUT; i++) begin
      wr(8 * (i + 1) + 2, 32'h0002_0003);
      wr(8 * (i + 1) + 4, 32'h0005_0001);
    end
    checkVec(2, "R8", "R8");

    // R9: restart in the middle of a running frame
    checkVec(0, "R9", "R9");

    // R2: hsync period is one line, vsync period one frame (vec0: 10 x 6)
    lastH = hsync[0]; lastV = vsync[0];
    firstH = -1; secH = -1; firstV = -1; secV = -1;
    for (int k = 0; k < 180; k++) begin
      step();
      if (hsync[0] && !lastH) begin
        if (firstH < 0) firstH = nCnt; else if (secH < 0) secH = nCnt;
      end
      if (vsync[0] && !lastV) begin
        if (firstV < 0) firstV = nCnt; else if (secV < 0) secV = nCnt;
      end
      lastH = hsync[0]; lastV = vsync[0];
    end
    check("R2", secH - firstH == 10, secH - firstH, 10, "hsync0 period");
    check("R2", secV - firstV == 60, secV - firstV, 60, "vsync0 period");

    // R11: mid-frame write to channel 0 hsync (5..7) must wait for the frame start
    repeat (3) step();
    wr(8, {16'd7, 16'd5});
    wN = nCnt;
    nb = ((wN / 60) + 1) * 60;
    badH = 0; badV = 0;
    while (nCnt < nb + 60) begin
      step();
      if (nCnt <= nb && hsync[0] !== hExp(nCnt, 10, 0, 3)) badH++;
      if (nCnt > nb + 10 && hsync[0] !== hExp(nCnt, 10, 5, 7)) badV++;
    end
    check("R11", badH == 0, badH, 0, "old timing kept for rest of frame");
    check("R11", badV == 0, badV, 0, "new timing from next frame");

    // R10: master mode ignores the reference input
    wr(2, 32'd0);
    nb = ((nCnt / 60) + 1) * 60;
    while (nCnt < nb + 5) step();
    extRef = 1'b1;
    step();
    extRef = 1'b0;
    stopN = nCnt + 120;
    badH = 0; badV = 0;
    while (nCnt < stopN) begin
      step();
      if (hsync[0] !== hExp(nCnt, 10, 5, 7)) badH++;
      if (vsync[0] !== vExp(nCnt, 10, 6, 1, 0, 2, 0)) badV++;
    end
    check("R10", badH == 0, badH, 0, "hsync0 phase after ignored reference");
    check("R10", badV == 0, badV, 0, "vsync0 phase after ignored reference");

    bad = 0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures + bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule